// File: doc/BRIEF.md
# Key-Protected Low-Speed Time-Base Selector

This block produces the slow tick that paces a real-time clock counter. It picks one of two sources. One is an internal RC oscillator path, which passes through a fixed predivider and then a 5-bit programmable prescaler. The other is an external crystal oscillator, whose rate is already in the 32 kHz class. Both oscillators arrive as single-cycle enable pulses in the system clock domain. The block returns a one-cycle `tick_o` pulse for each slow period, plus a copy of that tick that passes only when the clock-out gate is open.

Software cannot change the source by accident. A write to the control word lands only when its top half-word carries a fixed 16-bit key. The key is never stored and always reads back as zero.

A change of source goes through a two-stage handover. Ticks are held off while the new selection settles. When the internal path becomes active, its divider starts again from zero, so it never emits a shortened first period.

Top module: `lsclk_sel`

## Requirements
- R1: A bus write to offset 0x00 updates the control bits only when write data bits [31:16] equal 16'h16AA. Any other value leaves every control bit and the `ext_osc_on_o` and `fallback_bypass_o` outputs unchanged.
- R2: The control bits at offset 0x00 are: bit 0 selects the source (0 internal, 1 external), bit 4 drives `ext_osc_on_o`, and bit 15 drives `fallback_bypass_o`. A read of 0x00 returns these three bits at the same positions and zero in every other bit, including bits [31:16].
- R3: With the internal source active and `int_osc_en_i` held high, `tick_o` pulses once every PREDIV*(P+1) cycles. P is bits [4:0] of the register at offset 0x08. A read of 0x08 returns P in bits [4:0] and zero above.
- R4: If P is lowered below the prescaler's current count, the next predivided pulse produces a tick, so a tick follows the write within PREDIV cycles.
- R5: With the external source active, `tick_o` equals `ext_osc_en_i` delayed by one clock.
- R6: After a control write that changes the select bit, `tick_o` stays low on the two clock edges that follow the write edge. The new source drives `tick_o` from the third edge on.
- R7: On a switch to the internal source, the divider restarts from zero. The first internal tick appears on edge 2+PREDIV*(P+1) after the write edge.
- R8: Bit 0 of offset 0x60 gates the clock output. When it is 1, `clkout_en_o` equals `tick_o`; when it is 0, `clkout_en_o` stays low. A read of 0x60 returns the gate in bit 0.
- R9: After reset, the internal source is selected, P is 0 and the gate is closed. All three registers read zero and the tick period is PREDIV.
- R10: Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| int_osc_en_i | input | 1 | Pulse per internal RC oscillator period |
| ext_osc_en_i | input | 1 | Pulse per external oscillator period |
| ext_osc_on_o | output | 1 | Enable request to the external oscillator |
| fallback_bypass_o | output | 1 | Disables automatic fallback to the internal source |
| tick_o | output | 1 | One-cycle low-speed tick |
| clkout_en_o | output | 1 | Tick passed through the output gate |

## Verification
The bench tries each of the sixteen keys that differ from the correct one by a single bit. A design that compared fewer key bits would take one of those writes and switch source. It sweeps every prescaler value and measures exact periods, which exposes off-by-one dividers. It also lowers the prescaler below the running count: a design that waits for an exact match would run a full 32-step wrap before the next tick. Around each change of source it checks the exact edges where ticks are held off and where the first internal tick lands. A design that skipped the handover would leak a tick from the old or the new source, and one that kept a stale divider count would emit a short first period.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
   localparam int unsigned BUS_W     = 32;
   localparam int unsigned CTRL_OFS  = 'h00;
   localparam int unsigned PSC_OFS   = 'h08;
   localparam int unsigned GATE_OFS  = 'h60;
   localparam logic [15:0] CTRL_KEY  = 16'h16AA;
   localparam int unsigned SEL_POS   = 0;
   localparam int unsigned EXTON_POS = 4;
   localparam int unsigned BYP_POS   = 15;

   typedef struct packed {
      logic bypass;
      logic ext_on;
      logic sel;
   } ctrl_t;

   function automatic logic [BUS_W-1:0] ctrl_word(ctrl_t c);
      logic [BUS_W-1:0] w;
      w            = '0;
      w[SEL_POS]   = c.sel;
      w[EXTON_POS] = c.ext_on;
      w[BYP_POS]   = c.bypass;
      return w;
   endfunction
endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PSC_W  = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BUS_W-1:0]  wdata_i,
   output logic [BUS_W-1:0]  rdata_o,
   output ctrl_t             ctrl_o,
   output logic [PSC_W-1:0]  psc_o,
   output logic              gate_o
);
   logic hit_ctrl, hit_psc, hit_gate, key_ok;
   logic unused_wbits;

   assign hit_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
   assign hit_psc  = (addr_i == ADDR_W'(PSC_OFS));
   assign hit_gate = (addr_i == ADDR_W'(GATE_OFS));
   assign key_ok   = (wdata_i[BUS_W-1 -: 16] == CTRL_KEY);
   assign unused_wbits = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_o <= '0;
         psc_o  <= '0;
         gate_o <= 1'b0;
      end else if (we_i) begin
         if (hit_ctrl && key_ok) begin
            ctrl_o.sel    <= wdata_i[SEL_POS];
            ctrl_o.ext_on <= wdata_i[EXTON_POS];
            ctrl_o.bypass <= wdata_i[BYP_POS];
         end
         if (hit_psc)  psc_o  <= wdata_i[PSC_W-1:0];
         if (hit_gate) gate_o <= wdata_i[0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_ctrl)      rdata_o = ctrl_word(ctrl_o);
      else if (hit_psc)  rdata_o[PSC_W-1:0] = psc_o;
      else if (hit_gate) rdata_o[0] = gate_o;
   end
endmodule

// File: rtl/lsclk_divider.sv
module lsclk_divider #(
   parameter int PREDIV = 32,
   parameter int PSC_W  = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             osc_en_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             tick_o
);
   logic             pre_pulse;
   logic [PSC_W-1:0] psc_q;
   logic             wrap;

   generate
      if (PREDIV > 1) begin : g_prediv
         localparam int PW = $clog2(PREDIV);
         logic [PW-1:0] pre_q;
         assign pre_pulse = osc_en_i && (pre_q == PW'(PREDIV - 1));
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       pre_q <= '0;
            else if (clr_i)    pre_q <= '0;
            else if (osc_en_i) pre_q <= pre_pulse ? '0 : pre_q + 1'b1;
         end
      end else begin : g_no_prediv
         assign pre_pulse = osc_en_i;
      end
   endgenerate

   // Compare with >= so that lowering the prescaler below the count wraps at once.
   assign wrap = pre_pulse && (psc_q >= psc_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        psc_q <= '0;
      else if (clr_i)     psc_q <= '0;
      else if (pre_pulse) psc_q <= wrap ? '0 : psc_q + 1'b1;
   end

   assign tick_o = wrap;
endmodule

// File: rtl/lsclk_handover.sv
module lsclk_handover #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sel_req_i,
   input  logic int_tick_i,
   input  logic ext_tick_i,
   output logic tick_o,
   output logic busy_o,
   output logic active_o,
   output logic div_clr_o
);
   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[STAGES-2:0], sel_req_i};
   end

   assign active_o  = stage_q[STAGES-1];
   assign busy_o    = (stage_q != {STAGES{sel_req_i}});
   assign div_clr_o = busy_o | active_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_o <= 1'b0;
      else         tick_o <= !busy_o && (active_o ? ext_tick_i : int_tick_i);
   end
endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PREDIV = 32,
   parameter int PSC_W  = 5,
   parameter int STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic              int_osc_en_i,
   input  logic              ext_osc_en_i,
   output logic              ext_osc_on_o,
   output logic              fallback_bypass_o,
   output logic              tick_o,
   output logic              clkout_en_o
);
   generate
      if (ADDR_W < 7)                 begin : g_bad_addr  $error("ADDR_W too small for register map"); end
      if (PSC_W < 1 || PSC_W > 16)    begin : g_bad_psc   $error("PSC_W out of range"); end
      if (PREDIV < 1)                 begin : g_bad_pre   $error("PREDIV must be at least 1"); end
      if (STAGES < 2)                 begin : g_bad_stage $error("STAGES must be at least 2"); end
   endgenerate

   ctrl_t            ctrl_q;
   logic [PSC_W-1:0] psc_q;
   logic             gate_q;
   logic             int_tick, div_clr, sel_busy, sel_active;

   lsclk_regs #(.ADDR_W(ADDR_W), .PSC_W(PSC_W)) regs_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bus_we_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .ctrl_o  (ctrl_q),
      .psc_o   (psc_q),
      .gate_o  (gate_q)
   );

   lsclk_divider #(.PREDIV(PREDIV), .PSC_W(PSC_W)) div_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (div_clr),
      .osc_en_i (int_osc_en_i),
      .psc_i    (psc_q),
      .tick_o   (int_tick)
   );

   lsclk_handover #(.STAGES(STAGES)) hand_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_req_i  (ctrl_q.sel),
      .int_tick_i (int_tick),
      .ext_tick_i (ext_osc_en_i),
      .tick_o     (tick_o),
      .busy_o     (sel_busy),
      .active_o   (sel_active),
      .div_clr_o  (div_clr)
   );

   assign ext_osc_on_o      = ctrl_q.ext_on;
   assign fallback_bypass_o = ctrl_q.bypass;
   assign clkout_en_o       = tick_o & gate_q;
endmodule

// File: rtl/lsclk_sel_chk.sv
module lsclk_sel_chk
   import lsclk_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PSC_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_we_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic              ext_osc_en_i,
   input logic              tick_o,
   input ctrl_t             ctrl_q,
   input logic              sel_busy,
   input logic              sel_active
);
   AST_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_we_i && bus_addr_i == ADDR_W'(CTRL_OFS) && bus_wdata_i[31:16] != CTRL_KEY)
      |=> $stable(ctrl_q)); // R1

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_W'(CTRL_OFS)) |-> (bus_rdata_o[31:16] == 16'h0)); // R2

   AST_PSC_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == ADDR_W'(PSC_OFS)) |-> ((bus_rdata_o >> PSC_W) == 32'h0)); // R3

   AST_EXT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_busy && sel_active && ext_osc_en_i) |=> tick_o); // R5

   AST_HANDOVER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_busy |=> !tick_o); // R6

   AST_SEL_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_busy |-> (sel_active == ctrl_q.sel)); // R6
endmodule

bind lsclk_sel lsclk_sel_chk #(.ADDR_W(ADDR_W), .PSC_W(PSC_W)) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .bus_we_i     (bus_we_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .ext_osc_en_i (ext_osc_en_i),
   .tick_o       (tick_o),
   .ctrl_q       (ctrl_q),
   .sel_busy     (sel_busy),
   .sel_active   (sel_active)
);

// File: tb/lsclk_sel_tb_top.sv
`timescale 1ns/1ps
module lsclk_sel_tb_top;
   localparam int PREDIV = 4;
   localparam int ADDR_W = 8;
   localparam logic [15:0] KEY = 16'h16AA;
   localparam logic [7:0] A_CTRL = 8'h00, A_PSC = 8'h08, A_GATE = 8'h60;

   logic              clk = 1'b0, rst_n = 1'b0, we = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0, rdata;
   logic              int_en = 1'b0, ext_en = 1'b0;
   logic              ext_on, bypass, tick, clkout;
   int                checks = 0, fails = 0;
   bit                done = 1'b0;

   always #4 clk = ~clk;

   lsclk_sel #(.ADDR_W(ADDR_W), .PREDIV(PREDIV), .PSC_W(5)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .bus_we_i (we), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_rdata_o (rdata), .int_osc_en_i (int_en),
      .ext_osc_en_i (ext_en), .ext_osc_on_o (ext_on), .fallback_bypass_o (bypass),
      .tick_o (tick), .clkout_en_o (clkout)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a; #1; d = rdata;
   endtask

   task automatic wait_tick(input int lim, output int k);
      k = 0;
      do begin @(negedge clk); k++; end while (!tick && k < lim);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int k, nt, nc;
      logic [15:0] pats [4];
      pats[0] = 16'hA5C3; pats[1] = 16'hFFFF; pats[2] = 16'h0001; pats[3] = 16'h7E18;
      int_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(A_CTRL, v); chk(v == 0, "R9 ctrl", v, 0);
      rd(A_PSC, v);  chk(v == 0, "R9 psc", v, 0);
      rd(A_GATE, v); chk(v == 0, "R9 gate", v, 0);
      chk(!ext_on && !bypass, "R9 outs", {ext_on, bypass}, 0);
      wait_tick(100, k); wait_tick(100, k);
      chk(k == PREDIV, "R9 period", k, PREDIV);

      // R3 full prescaler sweep
      for (int p = 0; p < 32; p++) begin
         wr(A_PSC, 32'hFFFF_FFE0 | p);
         rd(A_PSC, v); chk(v == p, "R3 readback", v, p);
         wait_tick(400, k); wait_tick(400, k);
         chk(k == PREDIV * (p + 1), "R3 period", k, PREDIV * (p + 1));
      end

      // R4 lowering prescaler below running count
      wr(A_PSC, 31);
      wait_tick(400, k);
      repeat (50) @(negedge clk);
      wr(A_PSC, 0);
      wait_tick(400, k);
      chk(k >= 1 && k <= PREDIV, "R4 prompt tick", k, PREDIV);

      // R1 single-bit key errors
      for (int b = 0; b < 16; b++) begin
         wr(A_CTRL, {KEY ^ (16'd1 << b), 16'h8011});
         rd(A_CTRL, v);
         chk(v == 0 && !ext_on && !bypass, "R1 bad key ignored", v, 0);
      end
      // R2 field layout and readback
      wr(A_CTRL, {KEY, 16'hFFFF});
      rd(A_CTRL, v); chk(v == 32'h8011, "R2 readback", v, 32'h8011);
      chk(ext_on && bypass, "R2 outputs", {ext_on, bypass}, 2'b11);
      wr(A_CTRL, {KEY, 16'h0000});
      rd(A_CTRL, v); chk(v == 0 && !ext_on && !bypass, "R2 clear", v, 0);

      // R5 external follow
      int_en = 1'b0;
      wr(A_CTRL, {KEY, 16'h0011});
      repeat (4) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 16; j++) begin
            ext_en = pats[i][j];
            @(negedge clk);
            chk(tick == pats[i][j], "R5 follow", tick, pats[i][j]);
         end
      end

      // R6 and R7 switch to internal
      int_en = 1'b1; ext_en = 1'b1;
      wr(A_PSC, 2);
      wr(A_CTRL, {KEY, 16'h0000});
      @(negedge clk); chk(!tick, "R6 hold edge1", tick, 0);
      @(negedge clk); chk(!tick, "R6 hold edge2", tick, 0);
      k = 2;
      do begin @(negedge clk); k++; end while (!tick && k < 300);
      chk(k == 2 + PREDIV * 3, "R7 first internal tick", k, 2 + PREDIV * 3);

      // R6 switch to external
      wr(A_CTRL, {KEY, 16'h0011});
      @(negedge clk); chk(!tick, "R6 ext hold edge1", tick, 0);
      @(negedge clk); chk(!tick, "R6 ext hold edge2", tick, 0);
      @(negedge clk); chk(tick, "R6 ext takes over", tick, 1);

      // R8 output gate
      ext_en = 1'b0;
      wr(A_PSC, 0);
      wr(A_CTRL, {KEY, 16'h0000});
      repeat (10) @(negedge clk);
      wr(A_GATE, 32'hFFFF_FFFE);
      nt = 0; nc = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); nt += tick; nc += clkout;
      end
      chk(nt == 10 && nc == 0, "R8 gate closed", nc, 0);
      wr(A_GATE, 1);
      rd(A_GATE, v); chk(v == 1, "R8 readback", v, 1);
      nt = 0; nc = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); nt += tick; nc += clkout;
      end
      chk(nt == 10 && nc == 10, "R8 gate open", nc, 10);

      // R10 unmapped offsets
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h61, 32'hFFFF_FFFF);
      rd(8'h04, v); chk(v == 0, "R10 read 04", v, 0);
      rd(8'h61, v); chk(v == 0, "R10 read 61", v, 0);
      rd(A_GATE, v); chk(v == 1, "R10 gate kept", v, 1);
      rd(A_PSC, v);  chk(v == 0, "R10 psc kept", v, 0);
      rd(A_CTRL, v); chk(v == 0, "R10 ctrl kept", v, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule